// File: doc/BRIEF.md
# Write Buffer with Read Check

This block sits between a write-through cache and main memory and absorbs processor stores. Each store is an address with one data word. A store is taken into one of four slots in the cycle the buffer offers a free slot, and from the processor's point of view it is then complete. The buffer hands its entries to memory one at a time, oldest first, over a valid/ready handshake, at whatever pace memory sets.

Before a read miss goes to memory, the cache presents the read address to a lookup port. Every pending entry is compared with that address at once. When one or more entries match, the port returns the data of the most recently accepted match with a hit flag, so the read never sees a value older than one still waiting in the buffer. Occupancy, full and empty outputs show how many slots are in use.

Top module: `store_drain_buffer`

## Requirements
- R1: After a synchronous reset, empty is 1, full is 0, count is 0, mem_valid is 0 and rd_hit is 0.
- R2: While fewer than four entries are held, wr_ready is 1, a store with wr_valid high is accepted at that clock edge, and count is one higher in the next cycle.
- R3: With four entries held and mem_ready low, wr_ready is 0, and a store offered then is not stored: a lookup of its address afterwards misses and count stays 4.
- R4: With four entries held and mem_ready high, wr_ready is 1, so one entry leaves and one enters at the same edge and count stays 4.
- R5: mem_valid is 1 exactly when the buffer holds an entry; mem_addr and mem_data then show the oldest entry, which leaves when mem_valid and mem_ready are both high, so entries reach memory in the order they were accepted.
- R6: While mem_valid is 1 and mem_ready is 0, mem_valid, mem_addr and mem_data keep their values into the next cycle.
- R7: rd_hit is 1 in the same cycle as rd_addr when any held entry has that address, and rd_data is then the data of the most recently accepted entry with that address.
- R8: When no held entry has the lookup address, rd_hit is 0 and rd_data is 0.
- R9: count always equals the number of held entries and stays within 0 to 4; full is 1 only at 4 and empty is 1 only at 0.
- R10: Once an entry has been taken by memory, it no longer takes part in lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Processor offers a store |
| wr_addr | input | 32 | Store word address |
| wr_data | input | 32 | Store data word |
| wr_ready | output | 1 | Store is accepted this cycle when wr_valid is high |
| mem_valid | output | 1 | Oldest entry is offered to memory |
| mem_addr | output | 32 | Address of the oldest entry |
| mem_data | output | 32 | Data of the oldest entry |
| mem_ready | input | 1 | Memory takes the offered entry |
| rd_addr | input | 32 | Read-miss address to search for |
| rd_hit | output | 1 | A held entry matches rd_addr |
| rd_data | output | 32 | Data of the youngest matching entry, 0 on a miss |
| full | output | 1 | All four slots are held |
| empty | output | 1 | No slot is held |
| count | output | 3 | Number of held entries |

## Verification
The bench fills the buffer with repeated addresses, including four stores to one address, so a lookup that returned the oldest rather than the youngest match, or that searched slots outside the held range after a wrap, would return wrong data. It offers a store to a full buffer with memory stalled, where a design that overwrote a slot would later hit on that address or disturb the drain order, and then with memory ready, where a design that ignored the simultaneous retire would stall and lose throughput. Lookups right after a retire catch a design that still matches a departed entry, and a long run against an irregular memory ready pattern compares every drained word with a scoreboard to catch reordering, duplication or loss across pointer wrap.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    localparam int WB_ADDR_W = 32;
    localparam int WB_DATA_W = 32;

    typedef logic [WB_ADDR_W-1:0] wb_addr_t;
    typedef logic [WB_DATA_W-1:0] wb_data_t;

    // One buffered store
    typedef struct packed {
        wb_addr_t addr;
        wb_data_t data;
    } wb_entry_t;

    // Result of a read-miss search
    typedef struct packed {
        logic     hit;
        wb_data_t data;
    } wb_lookup_t;

    function automatic logic addr_match(input wb_addr_t a, input wb_addr_t b);
        return a == b;
    endfunction

endpackage

// File: rtl/wbuf_flow.sv
module wbuf_flow
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] count,
    input  logic             wr_valid,
    input  logic             mem_ready,
    output logic             wr_ready,
    output logic             push,
    output logic             pop,
    output logic             full,
    output logic             empty,
    output logic             mem_valid
);

    always_comb begin
        full      = (count == CNT_W'(DEPTH));
        empty     = (count == '0);
        mem_valid = !empty;
        pop       = mem_valid && mem_ready;
        // a retiring entry frees its slot for a store in the same cycle
        wr_ready  = !full || pop;
        push      = wr_valid && wr_ready;
    end

endmodule

// File: rtl/wbuf_ring.sv
module wbuf_ring
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  wb_entry_t        push_entry,
    output wb_entry_t        slots [DEPTH],
    output logic [PTR_W-1:0] head,
    output logic [CNT_W-1:0] count,
    output wb_entry_t        head_entry
);

    logic [PTR_W-1:0] tail;

    // Pointers and occupancy
    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= tail + 1'b1;
            if (pop)  head <= head + 1'b1;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Storage, no reset needed: only slots inside the held range are read
    always_ff @(posedge clk) begin
        if (push) slots[tail] <= push_entry;
    end

    assign head_entry = slots[head];

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)); // R9
    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_W'(DEPTH) && !pop) |-> !push); // R3
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> !pop); // R5
    AST_COUNT_UP: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> count == $past(count) + 1'b1); // R2
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> count == $past(count) - 1'b1); // R9

endmodule

// File: rtl/wbuf_search.sv
module wbuf_search
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  wb_entry_t        slots [DEPTH],
    input  logic [PTR_W-1:0] head,
    input  logic [CNT_W-1:0] count,
    input  wb_addr_t         key,
    output wb_lookup_t       result
);

    // Walk from oldest to youngest; a later match overrides an earlier one
    always_comb begin
        logic [PTR_W-1:0] idx;
        result = '0;
        idx    = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + PTR_W'(k);
            if ((CNT_W'(k) < count) && addr_match(slots[idx].addr, key)) begin
                result.hit  = 1'b1;
                result.data = slots[idx].data;
            end
        end
    end

endmodule

// File: rtl/store_drain_buffer.sv
module store_drain_buffer
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [31:0]      wr_addr,
    input  logic [31:0]      wr_data,
    output logic             wr_ready,
    output logic             mem_valid,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_data,
    input  logic             mem_ready,
    input  logic [31:0]      rd_addr,
    output logic             rd_hit,
    output logic [31:0]      rd_data,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);

    logic             push;
    logic             pop;
    logic [PTR_W-1:0] head;
    wb_entry_t        slots [DEPTH];
    wb_entry_t        head_entry;
    wb_entry_t        new_entry;
    wb_lookup_t       found;

    assign new_entry.addr = wr_addr;
    assign new_entry.data = wr_data;

    wbuf_flow #(.DEPTH(DEPTH)) u_flow (
        .count     (count),
        .wr_valid  (wr_valid),
        .mem_ready (mem_ready),
        .wr_ready  (wr_ready),
        .push      (push),
        .pop       (pop),
        .full      (full),
        .empty     (empty),
        .mem_valid (mem_valid)
    );

    wbuf_ring #(.DEPTH(DEPTH)) u_ring (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .pop        (pop),
        .push_entry (new_entry),
        .slots      (slots),
        .head       (head),
        .count      (count),
        .head_entry (head_entry)
    );

    wbuf_search #(.DEPTH(DEPTH)) u_search (
        .slots  (slots),
        .head   (head),
        .count  (count),
        .key    (rd_addr),
        .result (found)
    );

    assign mem_addr = head_entry.addr;
    assign mem_data = head_entry.data;
    assign rd_hit   = found.hit;
    assign rd_data  = found.data;

    AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr) && $stable(mem_data)); // R6
    AST_FULL_SWAP: assert property (@(posedge clk) disable iff (rst)
        (full && wr_valid && mem_ready) |=> full); // R4
    AST_HIT_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (rst)
        rd_hit |-> !empty); // R7
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_hit |-> rd_data == '0); // R8

endmodule

// File: tb/store_drain_buffer_bench.sv
module store_drain_buffer_bench;
    import wbuf_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wr_ready;
    logic        mem_valid;
    logic [31:0] mem_addr;
    logic [31:0] mem_data;
    logic        mem_ready;
    logic [31:0] rd_addr = '0;
    logic        rd_hit;
    logic [31:0] rd_data;
    logic        full;
    logic        empty;
    logic [2:0]  count;

    logic mem_ready_man = 1'b0;
    logic stream_en = 1'b0;
    logic pat = 1'b0;
    int   pat_cnt = 0;
    int   checks = 0;
    int   fails = 0;
    wb_entry_t exp_q[$];

    assign mem_ready = stream_en ? pat : mem_ready_man;

    always #5 clk = ~clk;

    store_drain_buffer u_store_drain_buffer (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ready(wr_ready), .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_ready(mem_ready), .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_data(rd_data),
        .full(full), .empty(empty), .count(count)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Irregular memory acceptance pattern for the streaming phase
    always @(posedge clk) begin
        #1;
        pat_cnt++;
        pat = ((pat_cnt % 7) != 3) && ((pat_cnt % 5) != 1);
    end

    // Monitor: every memory handshake must match the oldest expected store
    always @(negedge clk) begin
        if (!rst && mem_valid && mem_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected retire", {mem_addr, mem_data}, 64'h0);
            end else begin
                wb_entry_t e;
                e = exp_q.pop_front();
                check(mem_addr == e.addr && mem_data == e.data, "R5 drain order",
                      {mem_addr, mem_data}, {e.addr, e.data});
            end
        end
    end

    // Driver: offer one store, wait until accepted, record it as expected
    task automatic do_write(input logic [31:0] a, input logic [31:0] d, output int waits);
        waits = 0;
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        forever begin
            @(negedge clk);
            if (wr_ready) break;
            waits++;
        end
        exp_q.push_back('{addr: a, data: d});
        @(posedge clk); #1;
        wr_valid = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] a, input bit hit, input logic [31:0] d, input string req);
        rd_addr = a;
        #1;
        check(rd_hit == hit, req, rd_hit, hit);
        check(rd_data == d, req, rd_data, d);
    endtask

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog R5 actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int w;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(empty == 1'b1, "R1 empty", empty, 1);
        check(full == 1'b0, "R1 full", full, 0);
        check(count == 3'd0, "R1 count", count, 0);
        check(mem_valid == 1'b0, "R1 mem_valid", mem_valid, 0);
        check(rd_hit == 1'b0, "R1 rd_hit", rd_hit, 0);

        // Fill with memory stalled; each store accepted without waiting (R2)
        do_write(32'h10, 32'hA1, w); check(w == 0, "R2 first accept", w, 0);
        @(negedge clk); check(count == 3'd1, "R2 count step", count, 1);
        do_write(32'h20, 32'hB2, w); check(w == 0, "R2 accept", w, 0);
        do_write(32'h10, 32'hC3, w); check(w == 0, "R2 accept", w, 0);
        do_write(32'h30, 32'hD4, w); check(w == 0, "R2 accept", w, 0);
        @(negedge clk);
        check(full == 1'b1, "R9 full at four", full, 1);
        check(count == 3'd4, "R9 count four", count, 4);
        check(empty == 1'b0, "R9 not empty", empty, 0);
        check(mem_valid == 1'b1 && mem_addr == 32'h10, "R5 oldest offered", mem_addr, 32'h10);
        lookup(32'h10, 1'b1, 32'hC3, "R7 youngest match");
        lookup(32'h20, 1'b1, 32'hB2, "R7 single match");
        lookup(32'h99, 1'b0, 32'h0, "R8 miss");

        // Store offered to a full buffer with memory stalled (R3, R6)
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_addr = 32'h40; wr_data = 32'hE5;
        @(negedge clk);
        check(wr_ready == 1'b0, "R3 stall", wr_ready, 0);
        @(posedge clk); #1;
        @(negedge clk);
        check(wr_ready == 1'b0, "R3 stall held", wr_ready, 0);
        check(mem_valid && mem_addr == 32'h10 && mem_data == 32'hA1, "R6 offer held",
              {mem_addr, mem_data}, {32'h10, 32'hA1});
        @(posedge clk); #1;
        wr_valid = 1'b0;
        @(negedge clk);
        lookup(32'h40, 1'b0, 32'h0, "R3 stalled store absent");
        check(count == 3'd4, "R3 count unchanged", count, 4);

        // Full buffer, memory ready: swap in the same cycle (R4)
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_addr = 32'h40; wr_data = 32'hE5; mem_ready_man = 1'b1;
        @(negedge clk);
        check(wr_ready == 1'b1, "R4 accept while retiring", wr_ready, 1);
        exp_q.push_back('{addr: 32'h40, data: 32'hE5});
        @(posedge clk); #1;
        wr_valid = 1'b0; mem_ready_man = 1'b0;
        @(negedge clk);
        check(count == 3'd4 && full, "R4 count stays four", count, 4);
        check(mem_addr == 32'h20, "R5 next oldest", mem_addr, 32'h20);
        lookup(32'h40, 1'b1, 32'hE5, "R7 swapped entry");
        lookup(32'h10, 1'b1, 32'hC3, "R7 remaining match");

        // Retire one entry, its address must vanish (R10)
        @(posedge clk); #1 mem_ready_man = 1'b1;
        @(posedge clk); #1 mem_ready_man = 1'b0;
        @(negedge clk);
        lookup(32'h20, 1'b0, 32'h0, "R10 retired entry gone");
        check(count == 3'd3, "R9 count after retire", count, 3);

        // Drain the rest
        @(posedge clk); #1 mem_ready_man = 1'b1;
        repeat (3) @(posedge clk);
        #1 mem_ready_man = 1'b0;
        @(negedge clk);
        check(empty && !full && count == 3'd0, "R9 empty after drain", count, 0);
        check(mem_valid == 1'b0, "R5 no offer when empty", mem_valid, 0);
        check(exp_q.size() == 0, "R5 all drained", exp_q.size(), 0);
        lookup(32'h10, 1'b0, 32'h0, "R10 drained address misses");

        // Four stores to one address: youngest wins across wrapped pointers
        for (int i = 1; i <= 4; i++) begin
            do_write(32'h80, 32'(i), w);
        end
        @(negedge clk);
        lookup(32'h80, 1'b1, 32'h4, "R7 four same-address entries");
        @(posedge clk); #1 mem_ready_man = 1'b1;
        @(posedge clk); #1 mem_ready_man = 1'b0;
        @(negedge clk);
        lookup(32'h80, 1'b1, 32'h4, "R7 youngest after partial drain");
        @(posedge clk); #1 mem_ready_man = 1'b1;
        repeat (3) @(posedge clk);
        #1 mem_ready_man = 1'b0;

        // Streaming against an irregular memory
        stream_en = 1'b1;
        for (int i = 0; i < 24; i++) begin
            do_write(32'h100 + 32'((i % 5) * 4), 32'(i * 17 + 7), w);
        end
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (empty) break;
        end
        stream_en = 1'b0;
        @(negedge clk);
        check(empty == 1'b1, "R9 empty after stream", empty, 1);
        check(exp_q.size() == 0, "R5 stream fully drained", exp_q.size(), 0);

        summary();
        $finish;
    end

endmodule